// File: doc/BRIEF.md
# Multi-channel ADC trigger controller

This controller sits between a simple single-cycle register bus and a sixteen-channel successive-approximation converter core. Software powers the converter through an enable bit. After a settling interval it starts a conversion on a channel by raising that channel's bit in a shared trigger register. Triggers that arrive while a conversion is running are queued. They are issued to the core one at a time, lowest channel first.

Each result is stored in a per-channel result register together with a ready flag. A global busy flag tells software when the converter has gone quiet. Software clears a channel's ready flag by writing its trigger bit low, and then re-arms the channel by writing the bit high again.

The converter side uses two valid/ready channels. On the request channel the controller holds `adc_req_valid` and the channel number until the core accepts them with `adc_req_ready`. On the result channel the core may hold `adc_res_valid` with data for as long as it likes. The controller raises `adc_res_ready` only once the sample interval has elapsed, so the core sees back-pressure until then. `adc_en` tells the core it is powered; when it drops, the core discards any work in flight. Bus reads are combinational from `bus_addr`. Bus writes take effect on the clock edge where `bus_valid` and `bus_write` are both high.

Top module: `adc_trig_ctrl`

## Requirements
- R1: Only these byte offsets are decoded: 0x04 trigger, 0x10 status, 0x94 power, and 0x14 + 4·n for the result of channel n. Every other offset, including 0x00 and misaligned or out-of-range result offsets, reads as zero. Unused bits of decoded registers also read as zero.
- R2: A write to offset 0x04 that takes bit n from 0 to 1 requests one conversion on channel n. When the conversion completes, the result register reads the 12-bit value in bits [11:0] and a 1 in bit 12.
- R3: A write to offset 0x04 with bit n at 0 clears channel n's ready flag (bit 12). The stored 12-bit value is left unchanged.
- R4: Writing a 1 to a trigger bit that already holds 1 starts no conversion and does not clear that channel's ready flag.
- R5: Status bit 0 reads 1 from the cycle after a trigger is queued until the cycle after the last queued result is captured. It falls exactly one cycle after that capture.
- R6: Triggers that rise while the converter is busy are queued. Queued channels are served one at a time in ascending channel number.
- R7: Bit 14 at offset 0x94 enables the converter and reads back as written. Trigger edges written before PWR_CYC cycles have elapsed since enable are discarded, and no request is issued for them.
- R8: Writing bit 14 low aborts any conversion in flight and drops pending triggers. Busy reads 0 two cycles after the write, and all result values and ready flags are kept.
- R9: The request stays valid with a stable channel until accepted, and at most one conversion is outstanding at a time. The result is accepted exactly SAMPLE_CYC + 1 cycles after the request, when the core already holds its result valid.
- R10: Offset 0x04 reads back the last value written to it in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| adc_en | output | 1 | Converter power enable |
| adc_req_valid | output | 1 | Conversion request valid |
| adc_req_ready | input | 1 | Core accepts the request |
| adc_req_chan | output | 4 | Channel of the request |
| adc_res_valid | input | 1 | Core result valid |
| adc_res_ready | output | 1 | Controller accepts the result |
| adc_res_data | input | 12 | Conversion value |

## Verification
Directed patterns each cover one case:
- A single trigger shows that capture and busy timing are correct.
- A repeated write of 1 shows that an edge, not a level, starts a conversion.
- A trigger written during settling shows that early edges are discarded.
- A burst with the highest channel in flight shows that queued channels are ordered by number, not by arrival.

Random 16-bit trigger masks, each against a random accept delay on the request channel, show two things. Every channel's stored value and ready flag follow its own bit, and channels that were not triggered keep their old value. A disable during a conversion shows that an abort leaves earlier results intact.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DATA0 = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PWR   = 8'h94;
  localparam int PWR_EN_BIT = 14;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_CAPT} conv_st_t;
endpackage

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int PWR_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pwr_ok
);
  localparam int CW = $clog2(PWR_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q  <= '0;
      pwr_ok <= 1'b0;
    end else if (cnt_q == CW'(PWR_CYC)) begin
      pwr_ok <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_chan_arb.sv
module adc_chan_arb #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend,
  output logic           any,
  output logic [CW-1:0]  idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = CW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
  import adc_trig_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int DW         = 12,
  parameter int SAMPLE_CYC = 2500,
  localparam int CW  = $clog2(NCH),
  localparam int TW  = $clog2(SAMPLE_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          pwr_ok,
  input  logic          pick_any,
  input  logic [CW-1:0] pick_idx,
  output logic          grant,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [CW-1:0] req_chan,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic [DW-1:0] res_data,
  output logic          cap_valid,
  output logic [CW-1:0] cap_chan,
  output logic [DW-1:0] cap_data,
  output logic          active
);
  conv_st_t      st_q;
  logic [TW-1:0] tmr_q;

  assign grant     = (st_q == ST_IDLE) && pwr_ok && pick_any && !abort;
  assign req_valid = (st_q == ST_REQ) && !abort;
  assign res_ready = (st_q == ST_CAPT) && !abort;
  assign cap_valid = res_ready && res_valid;
  assign cap_data  = res_data;
  assign cap_chan  = req_chan;
  assign active    = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      st_q     <= ST_IDLE;
      tmr_q    <= '0;
      req_chan <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (grant) begin
          req_chan <= pick_idx;
          st_q     <= ST_REQ;
        end
        ST_REQ: if (req_ready) begin
          tmr_q <= TW'(SAMPLE_CYC - 1);
          st_q  <= ST_WAIT;
        end
        ST_WAIT: if (tmr_q == '0) st_q <= ST_CAPT;
                 else tmr_q <= tmr_q - 1'b1;
        ST_CAPT: if (res_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int DW         = 12,
  parameter int PWR_CYC    = 100000,
  parameter int SAMPLE_CYC = 2500,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              adc_en,
  output logic              adc_req_valid,
  input  logic              adc_req_ready,
  output logic [CW-1:0]     adc_req_chan,
  input  logic              adc_res_valid,
  output logic              adc_res_ready,
  input  logic [DW-1:0]     adc_res_data
);
  localparam logic [ADDR_W-1:0] DATA_SPAN = ADDR_W'(4 * NCH);

  logic           wr, trig_wr, pwr_wr;
  logic [NCH-1:0] trig_q, pend_q, rdy_vec, rise, gnt_mask;
  logic           en_q, busy_q, pwr_ok;
  logic           pick_any, grant, cap_valid, active;
  logic [CW-1:0]  pick_idx, cap_chan;
  logic [DW-1:0]  cap_data;
  logic [DW-1:0]  data_arr [NCH];

  assign wr      = bus_valid && bus_write;
  assign trig_wr = wr && (bus_addr == OFS_TRIG);
  assign pwr_wr  = wr && (bus_addr == OFS_PWR);
  assign rise    = trig_wr ? (bus_wdata[NCH-1:0] & ~trig_q) : '0;
  assign gnt_mask = grant ? (NCH'(1) << pick_idx) : '0;
  assign adc_en  = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= '0;
      en_q   <= 1'b0;
      pend_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (trig_wr) trig_q <= bus_wdata[NCH-1:0];
      if (pwr_wr)  en_q   <= bus_wdata[PWR_EN_BIT];
      if (!en_q) pend_q <= '0;
      else       pend_q <= (pend_q & ~gnt_mask) | (rise & {NCH{pwr_ok}});
      busy_q <= en_q && (active || (|pend_q));
    end
  end

  adc_pwr_seq #(.PWR_CYC(PWR_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .en(en_q), .pwr_ok(pwr_ok)
  );

  adc_chan_arb #(.NCH(NCH)) u_arb (
    .pend(pend_q), .any(pick_any), .idx(pick_idx)
  );

  adc_conv_fsm #(.NCH(NCH), .DW(DW), .SAMPLE_CYC(SAMPLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .abort(!en_q), .pwr_ok(pwr_ok),
    .pick_any(pick_any), .pick_idx(pick_idx), .grant(grant),
    .req_valid(adc_req_valid), .req_ready(adc_req_ready), .req_chan(adc_req_chan),
    .res_valid(adc_res_valid), .res_ready(adc_res_ready), .res_data(adc_res_data),
    .cap_valid(cap_valid), .cap_chan(cap_chan), .cap_data(cap_data),
    .active(active)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          rdy_r;
    logic [DW-1:0] dat_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy_r <= 1'b0;
        dat_r <= '0;
      end else if (cap_valid && cap_chan == CW'(g)) begin
        rdy_r <= 1'b1;
        dat_r <= cap_data;
      end else if (trig_wr && !bus_wdata[g]) begin
        rdy_r <= 1'b0;
      end
    end
    assign rdy_vec[g]  = rdy_r;
    assign data_arr[g] = dat_r;
  end

  logic [ADDR_W-1:0] res_ofs;
  logic              res_hit;
  logic [CW-1:0]     res_idx;
  assign res_ofs = bus_addr - OFS_DATA0;
  assign res_hit = (bus_addr >= OFS_DATA0) && (res_ofs < DATA_SPAN) && (res_ofs[1:0] == 2'b00);
  assign res_idx = res_ofs[CW+1:2];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_TRIG)      bus_rdata[NCH-1:0] = trig_q;
    else if (bus_addr == OFS_STAT) bus_rdata[0] = busy_q;
    else if (bus_addr == OFS_PWR)  bus_rdata[PWR_EN_BIT] = en_q;
    else if (res_hit)              bus_rdata[DW:0] = {rdy_vec[res_idx], data_arr[res_idx]};
  end
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [CW-1:0]  req_chan,
  input logic           res_ready,
  input logic           pwr_ok,
  input logic           en_q,
  input logic           busy_q,
  input logic           cap_valid,
  input logic [CW-1:0]  cap_chan,
  input logic [NCH-1:0] rdy_vec
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !en_q)
    req_valid && !req_ready |=> req_valid && $stable(req_chan));
  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && res_ready));
  // R7
  req_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> pwr_ok);
  // R2
  cap_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> rdy_vec[$past(cap_chan)]);
  // R8
  abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |=> !busy_q);
  // R5
  busy_at_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> busy_q);
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(adc_req_valid), .req_ready(adc_req_ready), .req_chan(adc_req_chan),
  .res_ready(adc_res_ready), .pwr_ok(pwr_ok), .en_q(en_q), .busy_q(busy_q),
  .cap_valid(cap_valid), .cap_chan(cap_chan), .rdy_vec(rdy_vec)
);

// File: tb/adc_trig_ctrl_tb.sv
module adc_trig_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int DW = 12;
  localparam int PWR_CYC = 20;
  localparam int SAMPLE_CYC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic adc_en, adc_req_valid, adc_res_ready;
  logic adc_req_ready, adc_res_valid;
  logic [3:0] adc_req_chan;
  logic [11:0] adc_res_data;

  int nchk = 0, nfail = 0;
  int cyc = 0, acc_cyc = 0, done_cyc = 0, nacc = 0, ndone = 0;
  int acc_log [256];
  logic [11:0] exp_data [NCH];
  logic [3:0] cur_ch;
  logic hold;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_trig_ctrl #(.NCH(NCH), .DW(DW), .PWR_CYC(PWR_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .adc_en(adc_en), .adc_req_valid(adc_req_valid), .adc_req_ready(adc_req_ready),
    .adc_req_chan(adc_req_chan), .adc_res_valid(adc_res_valid),
    .adc_res_ready(adc_res_ready), .adc_res_data(adc_res_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // converter core model: random accept delay, result held valid until taken
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || !adc_en) begin
      hold <= 1'b0; adc_res_valid <= 1'b0; adc_req_ready <= 1'b0;
    end else begin
      adc_req_ready <= !hold && ($urandom_range(0, 2) != 0);
      if (adc_req_valid && adc_req_ready) begin
        hold <= 1'b1; acc_cyc <= cyc; cur_ch <= adc_req_chan;
        adc_res_valid <= 1'b1; adc_res_data <= 12'($urandom);
        acc_log[nacc % 256] = int'(adc_req_chan);
        nacc++;
      end
      if (adc_res_valid && adc_res_ready) begin
        adc_res_valid <= 1'b0; hold <= 1'b0; done_cyc <= cyc;
        exp_data[cur_ch] = adc_res_data;
        ndone++;
        // R9: accepted exactly SAMPLE_CYC+1 cycles after request
        chk(cyc - acc_cyc == SAMPLE_CYC + 1, "R9 sample interval", cyc - acc_cyc, SAMPLE_CYC + 1);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] res_exp(input bit rdy, input logic [11:0] v);
    return {19'd0, rdy, v};
  endfunction

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    int n = 0;
    rd(8'h10, s);
    while (s[0] && n < 2000) begin rd(8'h10, s); n++; end
    chk(s == 0, tag, s, 0);
  endtask

  task automatic chk_ch(input int ch, input bit rdy, input string tag);
    logic [31:0] v;
    rd(8'(8'h14 + 4 * ch), v);
    chk(v == res_exp(rdy, exp_data[ch]), tag, v, res_exp(rdy, exp_data[ch]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, fall_cyc;
    void'($urandom(32'h5eed));
    for (int i = 0; i < NCH; i++) exp_data[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state and address map (R1)
    rd(8'h10, v); chk(v == 0, "R5 busy at reset", v, 0);
    rd(8'h94, v); chk(v == 0, "R7 power at reset", v, 0);
    rd(8'h04, v); chk(v == 0, "R10 trigger at reset", v, 0);
    chk_ch(0, 0, "R2 result at reset");
    rd(8'h00, v); chk(v == 0, "R1 offset 0x00", v, 0);
    rd(8'h16, v); chk(v == 0, "R1 misaligned", v, 0);
    rd(8'h54, v); chk(v == 0, "R1 past last channel", v, 0);
    chk(adc_req_valid == 0, "R9 no request at reset", adc_req_valid, 0);

    // R7: enable, early trigger discarded
    wr(8'h94, 32'h0000_4000);
    rd(8'h94, v); chk(v == 32'h4000, "R7 enable readback", v, 32'h4000);
    wr(8'h04, 32'h8);
    repeat (PWR_CYC + 10) @(negedge clk);
    chk(nacc == 0, "R7 early trigger issued", nacc, 0);
    chk_ch(3, 0, "R7 early trigger result");
    rd(8'h10, v); chk(v == 0, "R7 busy after early trigger", v, 0);
    wr(8'h04, 32'h0);

    // R2 / R5: single trigger and busy timing
    wr(8'h04, 32'h20);
    rd(8'h10, v); chk(v == 1, "R5 busy after trigger", v, 1);
    fall_cyc = 0;
    for (int n = 0; n < 200 && v[0]; n++) begin
      rd(8'h10, v);
      if (!v[0]) fall_cyc = cyc;
    end
    chk(fall_cyc == done_cyc + 2, "R5 busy fall cycle", fall_cyc, done_cyc + 2);
    chk_ch(5, 1, "R2 single conversion");
    rd(8'h04, v); chk(v == 32'h20, "R10 trigger readback", v, 32'h20);

    // R4: level re-write starts nothing
    base = nacc;
    wr(8'h04, 32'h20);
    repeat (20) @(negedge clk);
    chk(nacc == base, "R4 no conversion on level", nacc, base);
    chk_ch(5, 1, "R4 ready kept");

    // R3: write low clears ready, keeps data
    wr(8'h04, 32'h0);
    chk_ch(5, 0, "R3 ready cleared");

    // R6: ascending service of queued triggers
    base = nacc;
    wr(8'h04, 32'h8000);
    wr(8'h04, 32'h8C12);
    wait_idle("R6 idle after burst");
    chk(nacc - base == 5, "R6 count", nacc - base, 5);
    chk(acc_log[base % 256] == 15, "R6 order 0", acc_log[base % 256], 15);
    chk(acc_log[(base + 1) % 256] == 1, "R6 order 1", acc_log[(base + 1) % 256], 1);
    chk(acc_log[(base + 2) % 256] == 4, "R6 order 2", acc_log[(base + 2) % 256], 4);
    chk(acc_log[(base + 3) % 256] == 10, "R6 order 3", acc_log[(base + 3) % 256], 10);
    chk(acc_log[(base + 4) % 256] == 11, "R6 order 4", acc_log[(base + 4) % 256], 11);
    wr(8'h04, 32'h0);

    // random masks (R2, R3)
    for (int it = 0; it < 25; it++) begin
      logic [15:0] m;
      int c;
      m = 16'($urandom);
      if (m == 0) m = 16'h1;
      wr(8'h04, {16'h0, m});
      wait_idle("R2 idle after mask");
      for (int ch = 0; ch < NCH; ch++) chk_ch(ch, m[ch], "R2 random mask");
      wr(8'h04, 32'h0);
      c = $urandom_range(0, NCH - 1);
      chk_ch(c, 0, "R3 random clear");
    end

    // R8: abort keeps earlier results
    wr(8'h04, 32'h80);
    wait_idle("R8 idle before abort");
    base = ndone;
    wr(8'h04, 32'h180);
    repeat (3) @(negedge clk);
    wr(8'h94, 32'h0);
    rd(8'h10, v); chk(v == 0, "R8 busy after abort", v, 0);
    repeat (20) @(negedge clk);
    chk(ndone == base, "R8 no capture after abort", ndone, base);
    chk_ch(7, 1, "R8 ready kept");
    chk_ch(8, 0, "R8 aborted channel kept");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule